// File: doc/BRIEF.md
# Far-End Alarm Code Transmitter

This block sends a 6-bit far-end alarm and control code to the remote end of a framed serial link, one bit per outbound frame. The host loads the code into a holding register, sets the enable bit and pulses a start strobe. The block places the code inside a fixed 16-bit pattern. On each frame boundary pulse it gives the frame builder the next bit of that pattern, and it repeats the pattern for as long as it stays enabled. While it is disabled it outputs a constant 1, which the far end reads as idle.

The host learns that a transmission is complete through a sticky interrupt. The interrupt is raised once per started transmission, after the tenth full copy of the pattern has gone out. A start strobe given in the middle of a pattern is held until the current copy finishes. At that point the latest code is loaded and the copy count starts again.

The sequencer has three states:
- OFF: disabled, output all ones.
- ARMED: sending and counting copies toward the interrupt.
- FREE: sending, with no interrupt pending.

Its transitions are:
- OFF to ARMED on enable together with start.
- OFF to FREE on enable alone.
- ARMED to FREE when the tenth copy completes.
- ARMED or FREE to ARMED when a held start reaches a pattern boundary.
- Any state to OFF when enable drops.

Top module: `fac_tx`

## Requirements
- R1: After synchronous active-low reset, `code_bit_o` is 1 and `irq_o` is 0.
- R2: While the block is disabled, `code_bit_o` is 1 whatever frame ticks or code writes arrive, and the block is in state OFF from the cycle after `enable_i` is low.
- R3: Pattern bit index 0 is 0. Indexes 1 to 6 carry code bits 0 to 5, least significant first. Index 7 is 0 and indexes 8 to 15 are 1. `code_bit_o` shows the current bit, and each `frame_tick_i` consumes it and moves on to the next index.
- R4: While enabled, the pattern repeats without a gap: index 15 is followed by index 0. The copy counter stops at the target count and does not wrap.
- R5: When `irq_en_i` is high and a started transmission completes its tenth copy, `irq_o` is 1 from the cycle after the final frame tick of that copy.
- R6: `irq_o` stays set until `status_rd_i` or `irq_clr_i` is pulsed. If a set and a clear fall in the same cycle, the set wins.
- R7: The interrupt is raised at most once per start strobe. Further copies never raise it again.
- R8: A start strobe given mid-pattern lets the current copy finish. At the next pattern boundary the latest written code is sent from index 0 and the copy count restarts.
- R9: Enabling without a start sends the last written code from index 0 and never raises the interrupt.
- R10: With `irq_en_i` low, completing the tenth copy leaves `irq_o` at 0.
- R11: Dropping `enable_i` mid-pattern forces `code_bit_o` to 1 one cycle later. Re-enabling restarts at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Enable bit (level) |
| code_wr_i | input | 1 | Write strobe for the code register |
| code_i | input | 6 | Code value to write |
| start_i | input | 1 | Start-transmission strobe |
| irq_en_i | input | 1 | Interrupt enable |
| status_rd_i | input | 1 | Status read strobe, clears the interrupt |
| irq_clr_i | input | 1 | Write-one-to-clear strobe for the interrupt |
| frame_tick_i | input | 1 | Frame boundary pulse, consumes one bit |
| code_bit_o | output | 1 | Code bit for the current frame |
| irq_o | output | 1 | Sticky completion interrupt |

## Verification
The bench builds the block with its default parameters: a 6-bit code, eight trailing ones (a 16-bit pattern) and a ten-copy target. With these values the interrupt point is reached after 160 frame ticks, so the bench can run to completion, then past it into counter saturation, and still stay short. Under these parameters it covers:
- a restart held across a pattern boundary;
- disabling in the middle of a pattern;
- enabling without a start;
- a completion with the interrupt masked.

// File: rtl/fac_pkg.sv
package fac_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_FREE  = 2'd2
    } fac_state_e;
endpackage

// File: rtl/fac_code.sv
module fac_code #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_wr,
    input  logic [CODE_W-1:0] code_in,
    input  logic              load,
    output logic [CODE_W-1:0] shadow_o
);
    logic [CODE_W-1:0] host_q;
    logic [CODE_W-1:0] shadow_q;
    logic [CODE_W-1:0] load_src;

    // A write in the same cycle as a load is taken as the newest code
    assign load_src = code_wr ? code_in : host_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_q   <= '0;
            shadow_q <= '0;
        end else begin
            if (code_wr) host_q <= code_in;
            if (load) shadow_q <= load_src;
        end
    end

    assign shadow_o = shadow_q;
endmodule

// File: rtl/fac_pattern.sv
module fac_pattern #(
    parameter int CODE_W = 6,
    parameter int ONES_W = 8,
    localparam int PAT_LEN = CODE_W + ONES_W + 2,
    localparam int POS_W = $clog2(PAT_LEN)
) (
    input  logic [CODE_W-1:0] code,
    input  logic [POS_W-1:0]  pos,
    output logic              bit_o
);
    logic [PAT_LEN-1:0] pat;

    // index 0: zero, then code LSB first, then zero, then the ones run
    assign pat[0] = 1'b0;
    generate
        for (genvar i = 0; i < CODE_W; i++) begin : g_code
            assign pat[1+i] = code[i];
        end
        assign pat[CODE_W+1] = 1'b0;
        for (genvar j = 0; j < ONES_W; j++) begin : g_ones
            assign pat[CODE_W+2+j] = 1'b1;
        end
    endgenerate

    assign bit_o = pat[pos];
endmodule

// File: rtl/fac_seq.sv
module fac_seq
    import fac_pkg::*;
#(
    parameter int PAT_LEN = 16,
    parameter int REPEATS = 10,
    localparam int POS_W = $clog2(PAT_LEN),
    localparam int CNT_W = $clog2(REPEATS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start,
    input  logic             frame_tick,
    output logic [POS_W-1:0] pos_o,
    output logic             load_o,
    output logic             active_o,
    output logic             done_o
);
    localparam logic [POS_W-1:0] LAST = POS_W'(PAT_LEN - 1);

    fac_state_e        state_q, state_n;
    logic [POS_W-1:0]  pos_q, pos_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic              pend_q, pend_n;
    logic              at_wrap, at_rest, take_start;

    assign at_wrap    = frame_tick && (pos_q == LAST);
    assign at_rest    = !frame_tick && (pos_q == '0);
    assign take_start = (pend_q || start) && (at_wrap || at_rest);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            pos_q   <= '0;
            cnt_q   <= '0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            pos_q   <= pos_n;
            cnt_q   <= cnt_n;
            pend_q  <= pend_n;
        end
    end

    always_comb begin
        state_n = state_q;
        pos_n   = pos_q;
        cnt_n   = cnt_q;
        pend_n  = pend_q;
        load_o  = 1'b0;
        done_o  = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                pos_n  = '0;
                cnt_n  = '0;
                pend_n = 1'b0;
                if (enable) begin
                    load_o  = 1'b1;
                    state_n = start ? ST_ARMED : ST_FREE;
                end
            end
            ST_ARMED, ST_FREE: begin
                if (!enable) begin
                    state_n = ST_OFF;
                    pos_n   = '0;
                    cnt_n   = '0;
                    pend_n  = 1'b0;
                end else begin
                    if (frame_tick) pos_n = at_wrap ? '0 : pos_q + POS_W'(1);
                    if (at_wrap && cnt_q < CNT_W'(REPEATS)) cnt_n = cnt_q + CNT_W'(1);
                    if (state_q == ST_ARMED && at_wrap && cnt_q == CNT_W'(REPEATS - 1)) begin
                        done_o  = 1'b1;
                        state_n = ST_FREE;
                    end
                    if (start) pend_n = 1'b1;
                    if (take_start) begin
                        load_o  = 1'b1;
                        cnt_n   = '0;
                        pend_n  = 1'b0;
                        state_n = ST_ARMED;
                    end
                end
            end
            default: state_n = ST_OFF;
        endcase
    end

    assign pos_o    = pos_q;
    assign active_o = (state_q != ST_OFF);

    // R3: each consumed bit moves the index forward by one inside a copy
    assert_pos_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OFF && enable && frame_tick && pos_q != LAST)
        |=> pos_q == $past(pos_q) + POS_W'(1));

    // R4: copy counter never passes the target
    assert_cnt_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(REPEATS));

    // R2: a low enable always lands in OFF
    assert_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> state_q == ST_OFF);
endmodule

// File: rtl/fac_irq.sv
module fac_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic irq_o
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       irq_q <= 1'b0;
        else if (set_evt) irq_q <= 1'b1;
        else if (clr_evt) irq_q <= 1'b0;
    end

    assign irq_o = irq_q;

    // R6: a clear with no competing set empties the flag
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !set_evt) |=> !irq_q);

    // R6: without a clear the flag holds
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !clr_evt) |=> irq_q);
endmodule

// File: rtl/fac_tx.sv
module fac_tx #(
    parameter int CODE_W  = 6,
    parameter int ONES_W  = 8,
    parameter int REPEATS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              code_wr_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              start_i,
    input  logic              irq_en_i,
    input  logic              status_rd_i,
    input  logic              irq_clr_i,
    input  logic              frame_tick_i,
    output logic              code_bit_o,
    output logic              irq_o
);
    localparam int PAT_LEN = CODE_W + ONES_W + 2;
    localparam int POS_W   = $clog2(PAT_LEN);

    logic [POS_W-1:0]  pos;
    logic              load, active, done, pat_bit;
    logic [CODE_W-1:0] shadow;

    fac_seq #(.PAT_LEN(PAT_LEN), .REPEATS(REPEATS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable_i),
        .start      (start_i),
        .frame_tick (frame_tick_i),
        .pos_o      (pos),
        .load_o     (load),
        .active_o   (active),
        .done_o     (done)
    );

    fac_code #(.CODE_W(CODE_W)) u_code (
        .clk      (clk),
        .rst_n    (rst_n),
        .code_wr  (code_wr_i),
        .code_in  (code_i),
        .load     (load),
        .shadow_o (shadow)
    );

    fac_pattern #(.CODE_W(CODE_W), .ONES_W(ONES_W)) u_pat (
        .code  (shadow),
        .pos   (pos),
        .bit_o (pat_bit)
    );

    fac_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (done && irq_en_i),
        .clr_evt (status_rd_i || irq_clr_i),
        .irq_o   (irq_o)
    );

    assign code_bit_o = active ? pat_bit : 1'b1;

    // R2: disabled line is all ones from the following cycle
    assert_idle_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> code_bit_o);

    // R10: the interrupt only rises while it is enabled
    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(irq_en_i));
endmodule

// File: tb/fac_tx_bench.sv
module fac_tx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable_i = 1'b0, code_wr_i = 1'b0, start_i = 1'b0;
    logic [5:0] code_i = '0;
    logic       irq_en_i = 1'b0, status_rd_i = 1'b0, irq_clr_i = 1'b0;
    logic       frame_tick_i = 1'b0;
    logic       code_bit_o, irq_o;

    int checks = 0;
    int failures = 0;
    bit done_run = 1'b0;

    logic  exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    fac_tx u_fac_tx (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .code_wr_i(code_wr_i),
        .code_i(code_i), .start_i(start_i), .irq_en_i(irq_en_i),
        .status_rd_i(status_rd_i), .irq_clr_i(irq_clr_i),
        .frame_tick_i(frame_tick_i), .code_bit_o(code_bit_o), .irq_o(irq_o)
    );

    function automatic logic pbit(logic [5:0] c, int i);
        if (i == 0 || i == 7) return 1'b0;
        if (i <= 6) return c[i-1];
        return 1'b1;
    endfunction

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // monitor: compares the bit offered in each ticked frame
    always @(negedge clk) begin
        if (frame_tick_i) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL scoreboard actual=%b expected=<none>", code_bit_o);
            end else begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (code_bit_o !== e) begin
                    failures++;
                    $display("FAIL %s actual=%b expected=%b", t, code_bit_o, e);
                end
            end
        end
    end

    task automatic tick(logic exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        frame_tick_i = 1'b1;
        @(posedge clk); #1;
        frame_tick_i = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic send(logic [5:0] c, int from, int n, string tag);
        for (int k = 0; k < n; k++) tick(pbit(c, (from + k) % 16), tag);
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    localparam logic [5:0] CA = 6'b101101;
    localparam logic [5:0] CB = 6'b010011;
    localparam logic [5:0] CC = 6'b110001;

    initial begin
        repeat (3) cyc();
        check("R1 code_bit after reset", code_bit_o, 1'b1);
        check("R1 irq after reset", irq_o, 1'b0);
        rst_n = 1'b1;
        cyc();

        // R2: disabled, ticks and code writes give ones
        code_wr_i = 1'b1; code_i = 6'b000000; cyc(); code_wr_i = 1'b0;
        for (int k = 0; k < 4; k++) tick(1'b1, "R2 idle ones");

        // R3 R5: enable, write and start in one cycle
        irq_en_i = 1'b1; enable_i = 1'b1; code_wr_i = 1'b1; code_i = CA; start_i = 1'b1;
        cyc();
        code_wr_i = 1'b0; start_i = 1'b0;
        send(CA, 0, 159, "R3 pattern A");
        check("R5 irq before tenth copy ends", irq_o, 1'b0);
        send(CA, 15, 1, "R3 pattern A");
        check("R5 irq after tenth copy", irq_o, 1'b1);

        // R4 R6: keeps repeating, irq sticky, read clears
        send(CA, 0, 16, "R4 eleventh copy");
        check("R6 irq sticky", irq_o, 1'b1);
        status_rd_i = 1'b1; cyc(); status_rd_i = 1'b0;
        check("R6 cleared by read", irq_o, 1'b0);
        send(CA, 0, 192, "R4 saturated repeat");
        check("R7 no second irq", irq_o, 1'b0);

        // R8: start mid-pattern
        send(CA, 0, 5, "R8 before restart");
        code_wr_i = 1'b1; code_i = CB; start_i = 1'b1; cyc();
        code_wr_i = 1'b0; start_i = 1'b0;
        send(CA, 5, 11, "R8 old copy finishes");
        send(CB, 0, 159, "R8 new code");
        check("R8 count restarted", irq_o, 1'b0);
        send(CB, 15, 1, "R8 new code");
        check("R8 irq after ten new copies", irq_o, 1'b1);
        irq_clr_i = 1'b1; cyc(); irq_clr_i = 1'b0;
        check("R6 write-one clear", irq_o, 1'b0);

        // R11: disable mid-pattern
        send(CB, 0, 3, "R11 before disable");
        check("R11 bit before disable", code_bit_o, pbit(CB, 3));
        enable_i = 1'b0; cyc();
        check("R11 ones after disable", code_bit_o, 1'b1);
        for (int k = 0; k < 3; k++) tick(1'b1, "R2 disabled ones");

        // R9: enable without start uses last written code
        code_wr_i = 1'b1; code_i = CC; cyc(); code_wr_i = 1'b0;
        check("R2 code write while off", code_bit_o, 1'b1);
        enable_i = 1'b1; cyc();
        send(CC, 0, 160, "R9 last code from index 0");
        check("R9 no irq without start", irq_o, 1'b0);

        // R10: masked completion
        irq_en_i = 1'b0;
        start_i = 1'b1; cyc(); start_i = 1'b0;
        send(CC, 0, 160, "R10 masked run");
        check("R10 irq stays low", irq_o, 1'b0);
        irq_en_i = 1'b1; cyc();
        check("R10 irq after unmask", irq_o, 1'b0);

        cyc();
        check("scoreboard drained", exp_q.size() == 0, 1'b1);
        done_run = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done_run) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule